// File: doc/BRIEF.md
# Multi-standard audio serial transmitter

This block turns 16-bit host writes into a two-channel serial audio stream on three lines: bit clock, word select and serial data. It covers the Philips framing, MSB-justified and LSB-justified framing, and a PCM framing with a short or long frame-sync pulse. Samples can be 16, 24 or 32 bits wide and sit in 16-bit or 32-bit channel slots. Bits the sample does not fill are driven as hardware zeros. Because the host path is 16 bits wide, a 24-bit or 32-bit sample takes two writes: the upper half first, then the lower half.

A single holding register sits between the host and the shifter. `txe` is high while that register can take a write, so it can serve directly as a DMA request. `chside` tells the host which channel its next complete sample will belong to. Frames always begin with the left channel. In master mode the block divides the system clock to make the bit clock. In clock-follower mode it shifts on the falling edges of an external bit clock, still builds the framing itself, and raises a sticky underflow flag when a slot starts with nothing to send.

Dropping `en` never cuts a frame short. The frame in flight is completed, `busy` then falls, and the lines return to idle.

Top module: `i2s_tx_port`

## Requirements
- R1: After reset, txe=1, busy=0, chside=0, udr=0, and sck_out, ws_out and sd_out are all low.
- R2: cfg_fmt selects the sample width: 0 for 16 bits, 1 for 24 bits, 2 or 3 for 32 bits. A 16-bit sample is complete after one write. A wider sample takes two writes, upper half first, and txe stays high until the second write. Once a sample is complete, txe is low until a slot takes the sample, and chside toggles (0 = left, 1 = right).
- R3: Samples go out MSB first. In master mode sck_out idles low and has a period of 2*DIV_HALF clock cycles. sd_out and ws_out change only on its falling edges, so every bit is stable at the rising edge.
- R4: cfg_std=0 (Philips): ws_out is low for the left channel and high for the right. It changes one bit before the MSB of each slot.
- R5: cfg_std=1 (MSB-justified): ws_out changes on the same bit as the MSB of the slot.
- R6: cfg_std=2 (LSB-justified): the sample's LSB is the last bit of the slot, and the bits ahead of the sample are zero.
- R7: A 16-bit sample in a 32-bit slot (cfg_slot32=1) is followed by 16 zero bits. For a 24-bit sample, the low 8 bits of the second write are replaced by zeros. Formats wider than 16 bits always use 32-bit slots, whatever cfg_slot32 says.
- R8: cfg_std=3 (PCM): ws_out carries a frame sync at every slot. With cfg_long_sync=0 it is a one-bit pulse on the last bit before the MSB. With cfg_long_sync=1 it is high for LONG_SYNC bits, starting with the MSB.
- R9: A sample is loaded only into a slot of the same channel it was written for. A left sample still held when a right slot starts stays held until the next left slot.
- R10: In master mode, a slot that starts with no matching sample repeats the last sample sent, and udr stays low.
- R11: With cfg_slave=1, bits advance on falling edges of sck_in and sck_out stays low. A slot that starts with no matching sample sets udr, and the next host write clears it.
- R12: A write while the holding register is full (txe=0) is ignored.
- R13: After en falls, the current frame is completed. busy stays high until its last bit has been sampled, then falls, and sd_out and ws_out return low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run request; sampled at each frame boundary |
| cfg_std | input | 2 | Framing standard |
| cfg_fmt | input | 2 | Sample width |
| cfg_slot32 | input | 1 | 32-bit slot for 16-bit samples |
| cfg_long_sync | input | 1 | Long PCM frame sync |
| cfg_slave | input | 1 | Follow the external bit clock |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 16 | Host write data |
| sck_in | input | 1 | External bit clock in follower mode |
| txe | output | 1 | Holding register can accept a write (DMA request) |
| chside | output | 1 | Channel of the next complete sample (0 = left) |
| busy | output | 1 | A frame is in progress |
| udr | output | 1 | Sticky underflow in follower mode |
| sck_out | output | 1 | Bit clock in master mode |
| ws_out | output | 1 | Word select or frame sync |
| sd_out | output | 1 | Serial data |

## Verification
The hardest case to reach from the ports is a holding register that holds a sample tagged for the wrong channel at the moment a slot starts. To get there, the bench enables the port with nothing loaded and writes a left sample part way into the first left slot. It then keeps `en` high across two frames, so the right slot of the first frame must skip that sample and the left slot of the second frame must pick it up. Underflow needs follower mode, so the bench drives its own slow `sck_in` and watches `udr` rise at the first empty slot and clear on the next write.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
   localparam int HOST_W    = 16;
   localparam int SLOT_MAX  = 2 * HOST_W;
   localparam int FRAME_MAX = 2 * SLOT_MAX;
   localparam int POS_W     = $clog2(FRAME_MAX);

   typedef enum logic [1:0] {
      STD_PHILIPS = 2'd0,
      STD_MSB     = 2'd1,
      STD_LSB     = 2'd2,
      STD_PCM     = 2'd3
   } tx_std_e;

   typedef enum logic [1:0] {
      FMT_16  = 2'd0,
      FMT_24  = 2'd1,
      FMT_32  = 2'd2,
      FMT_32B = 2'd3
   } tx_fmt_e;
endpackage

// File: rtl/i2s_tx_clkgen.sv
module i2s_tx_clkgen #(
   parameter int DIV_HALF    = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic slave,
   input  logic sck_in,
   output logic sck_o,
   output logic fall_ev
);
   logic tick;
   logic sck_q;
   logic [SYNC_STAGES:0] sy;

   generate
      if (DIV_HALF == 1) begin : g_nodiv
         assign tick = 1'b1;
      end else begin : g_div
         localparam int CW = $clog2(DIV_HALF);
         localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);
         logic [CW-1:0] dcnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               dcnt <= '0;
            else if (!run || slave)   dcnt <= '0;
            else if (dcnt == LAST)    dcnt <= '0;
            else                      dcnt <= dcnt + 1'b1;
         end
         assign tick = (dcnt == LAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              sck_q <= 1'b0;
      else if (!run || slave)  sck_q <= 1'b0;
      else if (tick)           sck_q <= ~sck_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sy <= '0;
      else        sy <= {sy[SYNC_STAGES-1:0], sck_in};
   end

   assign sck_o   = sck_q;
   assign fall_ev = (run && !slave && tick && sck_q) ||
                    (slave && sy[SYNC_STAGES] && !sy[SYNC_STAGES-1]);

   // R3
   sck_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !slave && !tick) |=> ($stable(sck_o) || !run));
   // R11
   follower_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slave |=> !sck_o);
endmodule

// File: rtl/i2s_tx_hold.sv
module i2s_tx_hold
   import i2s_tx_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [HOST_W-1:0]   wr_data,
   input  logic [1:0]          fmt,
   input  logic                take,
   output logic                full,
   output logic [SLOT_MAX-1:0] word,
   output logic                word_ch,
   output logic                side
);
   logic part;
   logic two;
   logic accept;
   logic [HOST_W-1:0] lo_next;

   assign two     = (fmt != FMT_16);
   assign accept  = wr_en && !full;
   assign lo_next = (fmt == FMT_24) ?
                    {wr_data[HOST_W-1:HOST_W/2], {(HOST_W/2){1'b0}}} : wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full    <= 1'b0;
         part    <= 1'b0;
         word    <= '0;
         word_ch <= 1'b0;
         side    <= 1'b0;
      end else begin
         if (take) full <= 1'b0;
         if (accept) begin
            if (!two) begin
               word    <= {wr_data, {HOST_W{1'b0}}};
               full    <= 1'b1;
               part    <= 1'b0;
               word_ch <= side;
               side    <= ~side;
            end else if (!part) begin
               word[SLOT_MAX-1:HOST_W] <= wr_data;
               part <= 1'b1;
            end else begin
               word[HOST_W-1:0] <= lo_next;
               part    <= 1'b0;
               full    <= 1'b1;
               word_ch <= side;
               side    <= ~side;
            end
         end
      end
   end

   // R12
   full_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && full) |=> ($stable(word) && $stable(side)));
   // R2
   sample_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && (!two || part)) |=> (full && (side != $past(side))));
   // R2
   half_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && two && !part) |=> !full);
endmodule

// File: rtl/i2s_tx_frame.sv
module i2s_tx_frame
   import i2s_tx_pkg::*;
#(
   parameter int LONG_SYNC = 13
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic                fall_ev,
   input  logic [1:0]          std,
   input  logic [1:0]          fmt,
   input  logic                slot32_req,
   input  logic                long_sync,
   input  logic                slave,
   input  logic                full,
   input  logic [SLOT_MAX-1:0] word,
   input  logic                word_ch,
   input  logic                wr_en,
   output logic                run,
   output logic                take,
   output logic                sd_o,
   output logic                ws_o,
   output logic                udr
);
   localparam logic [POS_W-2:0] LS = (POS_W-1)'(LONG_SYNC);

   logic [POS_W-1:0]    pos, last_pos, nxt_pos;
   logic [POS_W-2:0]    q, slot_end;
   logic [SLOT_MAX-1:0] shreg, last_w, aligned, new_w;
   logic                slot32, ch, nxt_ch, ws_next, can_load;
   logic                start_ev, stop_ev, drive_ev, slot_start;
   int unsigned         lsb_sh;

   assign slot32   = slot32_req || (fmt != FMT_16);
   assign last_pos = slot32 ? POS_W'(FRAME_MAX - 1) : POS_W'(SLOT_MAX - 1);
   assign ch       = slot32 ? pos[POS_W-1] : pos[POS_W-2];
   assign q        = slot32 ? pos[POS_W-2:0] : {1'b0, pos[POS_W-3:0]};
   assign slot_end = slot32 ? (POS_W-1)'(SLOT_MAX - 1) : (POS_W-1)'(HOST_W - 1);
   assign nxt_pos  = (pos == last_pos) ? '0 : pos + 1'b1;
   assign nxt_ch   = slot32 ? nxt_pos[POS_W-1] : nxt_pos[POS_W-2];

   assign start_ev   = !run && en;
   assign stop_ev    = run && fall_ev && (pos == '0) && !en;
   assign drive_ev   = start_ev || (run && fall_ev && !stop_ev);
   assign slot_start = drive_ev && (q == '0);
   assign can_load   = full && (word_ch == ch);
   assign take       = slot_start && can_load;

   always_comb begin
      lsb_sh = 0;
      if (slot32 && std == STD_LSB) begin
         case (fmt)
            FMT_16:  lsb_sh = SLOT_MAX - HOST_W;
            FMT_24:  lsb_sh = HOST_W / 2;
            default: lsb_sh = 0;
         endcase
      end
      aligned = word >> lsb_sh;
      new_w   = can_load ? aligned : last_w;
   end

   always_comb begin
      case (std)
         STD_PHILIPS: ws_next = nxt_ch;
         STD_PCM:     ws_next = long_sync ? (q < LS) : (q == slot_end);
         default:     ws_next = ch;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run    <= 1'b0;
         pos    <= '0;
         shreg  <= '0;
         last_w <= '0;
         sd_o   <= 1'b0;
         ws_o   <= 1'b0;
      end else if (stop_ev) begin
         run  <= 1'b0;
         pos  <= '0;
         sd_o <= 1'b0;
         ws_o <= 1'b0;
      end else if (drive_ev) begin
         run  <= 1'b1;
         pos  <= nxt_pos;
         ws_o <= ws_next;
         if (slot_start) begin
            sd_o   <= new_w[SLOT_MAX-1];
            shreg  <= new_w << 1;
            last_w <= new_w;
         end else begin
            sd_o  <= shreg[SLOT_MAX-1];
            shreg <= shreg << 1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 udr <= 1'b0;
      else if (slot_start && !can_load && slave)  udr <= 1'b1;
      else if (wr_en)                             udr <= 1'b0;
   end

   // R3
   sd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(drive_ev || stop_ev) |=> ($stable(sd_o) && $stable(ws_o)));
   // R13
   frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run) |-> ($past(pos) == '0));
   // R10
   udr_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(udr) |-> slave);
   // R9
   load_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_start && full && (word_ch != ch)) |=> full);
endmodule

// File: rtl/i2s_tx_port.sv
module i2s_tx_port
   import i2s_tx_pkg::*;
#(
   parameter int DIV_HALF    = 2,
   parameter int SYNC_STAGES = 2,
   parameter int LONG_SYNC   = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [1:0]        cfg_std,
   input  logic [1:0]        cfg_fmt,
   input  logic              cfg_slot32,
   input  logic              cfg_long_sync,
   input  logic              cfg_slave,
   input  logic              wr_en,
   input  logic [HOST_W-1:0] wr_data,
   input  logic              sck_in,
   output logic              txe,
   output logic              chside,
   output logic              busy,
   output logic              udr,
   output logic              sck_out,
   output logic              ws_out,
   output logic              sd_out
);
   initial begin
      if (DIV_HALF < 1)                        $error("DIV_HALF must be at least 1");
      if (SYNC_STAGES < 2)                     $error("SYNC_STAGES must be at least 2");
      if (LONG_SYNC < 1 || LONG_SYNC >= HOST_W) $error("LONG_SYNC out of range");
   end

   logic                run, fall_ev, take, full, word_ch, side;
   logic [SLOT_MAX-1:0] word;

   i2s_tx_clkgen #(.DIV_HALF(DIV_HALF), .SYNC_STAGES(SYNC_STAGES)) u_clk (
      .clk(clk), .rst_n(rst_n), .run(run), .slave(cfg_slave),
      .sck_in(sck_in), .sck_o(sck_out), .fall_ev(fall_ev)
   );

   i2s_tx_hold u_hold (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .fmt(cfg_fmt), .take(take), .full(full), .word(word),
      .word_ch(word_ch), .side(side)
   );

   i2s_tx_frame #(.LONG_SYNC(LONG_SYNC)) u_frame (
      .clk(clk), .rst_n(rst_n), .en(en), .fall_ev(fall_ev),
      .std(cfg_std), .fmt(cfg_fmt), .slot32_req(cfg_slot32),
      .long_sync(cfg_long_sync), .slave(cfg_slave), .full(full),
      .word(word), .word_ch(word_ch), .wr_en(wr_en), .run(run),
      .take(take), .sd_o(sd_out), .ws_o(ws_out), .udr(udr)
   );

   assign txe    = !full;
   assign chside = side;
   assign busy   = run;

   // R1
   idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> (!sd_out || busy));
endmodule

// File: tb/i2s_tx_port_tb.sv
module i2s_tx_port_tb;
   localparam int CLK_P      = 10;
   localparam int BENCH_DIV  = 2;
   localparam int BENCH_LONG = 13;
   localparam int NVEC       = 8;
   // {std, fmt, slot32, long, left, right}
   localparam logic [69:0] VECS [NVEC] = '{
      {2'd0, 2'd0, 1'b0, 1'b0, 32'h0000_8001, 32'h0000_7FFE},
      {2'd0, 2'd0, 1'b1, 1'b0, 32'h0000_A5C3, 32'h0000_1234},
      {2'd1, 2'd1, 1'b1, 1'b0, 32'h0012_3456, 32'h00FE_DCBA},
      {2'd2, 2'd1, 1'b0, 1'b0, 32'h00AB_CDEF, 32'h0000_F00F},
      {2'd2, 2'd0, 1'b1, 1'b0, 32'h0000_BEEF, 32'h0000_CAFE},
      {2'd3, 2'd0, 1'b0, 1'b0, 32'h0000_9669, 32'h0000_0F0F},
      {2'd3, 2'd2, 1'b1, 1'b1, 32'hDEAD_BEEF, 32'h0123_4567},
      {2'd1, 2'd2, 1'b1, 1'b0, 32'h8000_0001, 32'h7FFF_FFFF}
   };

   logic clk = 1'b0;
   logic rst_n, en, cfg_slot32, cfg_long_sync, cfg_slave, wr_en, sck_in;
   logic [1:0] cfg_std, cfg_fmt;
   logic [15:0] wr_data;
   logic txe, chside, busy, udr, sck_out, ws_out, sd_out;
   int n_chk = 0, n_fail = 0;
   bit done = 0, slv_run = 0;

   i2s_tx_port #(.DIV_HALF(BENCH_DIV), .SYNC_STAGES(2), .LONG_SYNC(BENCH_LONG)) u_dut (
      .clk(clk), .rst_n(rst_n), .en(en), .cfg_std(cfg_std), .cfg_fmt(cfg_fmt),
      .cfg_slot32(cfg_slot32), .cfg_long_sync(cfg_long_sync), .cfg_slave(cfg_slave),
      .wr_en(wr_en), .wr_data(wr_data), .sck_in(sck_in), .txe(txe), .chside(chside),
      .busy(busy), .udr(udr), .sck_out(sck_out), .ws_out(ws_out), .sd_out(sd_out)
   );

   always #(CLK_P/2) clk = ~clk;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic int slot_len(input logic [1:0] fmt, input logic s32);
      return (s32 || fmt != 2'd0) ? 32 : 16;
   endfunction

   function automatic int samp_w(input logic [1:0] fmt);
      return (fmt == 2'd0) ? 16 : (fmt == 2'd1) ? 24 : 32;
   endfunction

   function automatic logic exp_sd(input logic [1:0] std, input logic [1:0] fmt, input logic s32,
                                   input logic [31:0] l, input logic [31:0] r, input int p);
      int sl = slot_len(fmt, s32);
      int w  = samp_w(fmt);
      int q  = p % sl;
      logic [31:0] s = ((p / sl) % 2 == 1) ? r : l;
      int off = (std == 2'd2) ? sl - w : 0;
      if (q < off || q - off >= w) return 1'b0;
      return s[w - 1 - (q - off)];
   endfunction

   function automatic logic exp_ws(input logic [1:0] std, input logic [1:0] fmt, input logic s32,
                                   input logic lng, input int p);
      int sl = slot_len(fmt, s32);
      int fl = 2 * sl;
      case (std)
         2'd0:    return (((p + 1) % fl) >= sl);
         2'd3:    return lng ? ((p % sl) < BENCH_LONG) : ((p % sl) == sl - 1);
         default: return ((p % fl) >= sl);
      endcase
   endfunction

   task automatic write_word(input logic [15:0] w);
      @(negedge clk);
      while (!txe) @(negedge clk);
      wr_en = 1'b1; wr_data = w;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic write_sample(input logic [1:0] fmt, input logic [31:0] s);
      if (fmt == 2'd0) write_word(s[15:0]);
      else if (fmt == 2'd1) begin write_word(s[23:8]); write_word({s[7:0], 8'hA5}); end
      else begin write_word(s[31:16]); write_word(s[15:0]); end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; en = 1'b0; wr_en = 1'b0; wr_data = '0; sck_in = 1'b0;
      cfg_std = '0; cfg_fmt = '0; cfg_slot32 = 1'b0; cfg_long_sync = 1'b0; cfg_slave = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic capture(input int nbits, input int drop_at, output logic [63:0] sdv,
                          output logic [63:0] wsv, output logic mid_busy, output time per);
      time t0 = 0;
      sdv = '0; wsv = '0; mid_busy = 1'b0; per = 0;
      for (int p = 0; p < nbits; p++) begin
         @(posedge sck_out);
         #1;
         sdv[p] = sd_out; wsv[p] = ws_out;
         if (p == 0) t0 = $time;
         if (p == 1) per = $time - t0;
         if (p == nbits / 2) mid_busy = busy;
         if (p == drop_at) en = 1'b0;
      end
   endtask

   task automatic run_frame(input logic [1:0] std, input logic [1:0] fmt, input logic s32,
                            input logic lng, input logic [31:0] l, input logic [31:0] r,
                            input bit wr_l, input bit wr_r, input int idx);
      logic [63:0] sdv, wsv, esd, ews;
      logic mb;
      time per;
      int fl = 2 * slot_len(fmt, s32);
      string wtag;
      @(negedge clk);
      cfg_std = std; cfg_fmt = fmt; cfg_slot32 = s32; cfg_long_sync = lng; cfg_slave = 1'b0;
      if (wr_l) write_sample(fmt, l);
      fork
         begin @(negedge clk); en = 1'b1; @(negedge clk); en = 1'b0; end
         begin if (wr_r) begin repeat (2) @(negedge clk); write_sample(fmt, r); end end
         capture(fl, -1, sdv, wsv, mb, per);
      join
      esd = '0; ews = '0;
      for (int p = 0; p < fl; p++) begin
         esd[p] = exp_sd(std, fmt, s32, l, r, p);
         ews[p] = exp_ws(std, fmt, s32, lng, p);
      end
      wtag = (std == 2'd0) ? "R4" : (std == 2'd1) ? "R5" : (std == 2'd2) ? "R6" : "R8";
      // R3 R7: data bits, MSB first, padding zeros
      chk(sdv == esd, $sformatf("R3 R7 data of case %0d", idx), sdv, esd);
      chk(wsv == ews, $sformatf("%s word select of case %0d", wtag, idx), wsv, ews);
      if (idx == 0) chk(per == 2 * BENCH_DIV * CLK_P, "R3 bit clock period", per, 2 * BENCH_DIV * CLK_P);
      chk(mb == 1'b1, $sformatf("R13 busy mid frame of case %0d", idx), mb, 1);
      repeat (6) @(negedge clk);
      chk(!busy && !sd_out && !ws_out, $sformatf("R13 idle after frame of case %0d", idx),
          {busy, sd_out, ws_out}, 0);
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [63:0] sdv, wsv, esd, ews;
      logic mb;
      time per;

      do_reset();
      // R1: reset state
      chk(txe && !busy && !chside && !udr, "R1 flags after reset", {txe, busy, chside, udr}, 4'b1000);
      chk(!sck_out && !ws_out && !sd_out, "R1 lines after reset", {sck_out, ws_out, sd_out}, 0);

      // table of framing cases
      for (int i = 0; i < NVEC; i++) begin
         run_frame(VECS[i][69:68], VECS[i][67:66], VECS[i][65], VECS[i][64],
                   VECS[i][63:32], VECS[i][31:0], 1'b1, 1'b1, i);
      end

      // R2: two-write sample handshake
      do_reset();
      cfg_fmt = 2'd1;
      write_word(16'h1122);
      chk(txe && !chside, "R2 after upper half", {txe, chside}, 2'b10);
      write_word(16'h3344);
      chk(!txe && chside, "R2 after lower half", {txe, chside}, 2'b01);

      // R12: write while full is ignored
      do_reset();
      cfg_fmt = 2'd0;
      write_word(16'hA1A1);
      @(negedge clk); wr_en = 1'b1; wr_data = 16'h5E5E;
      @(negedge clk); wr_en = 1'b0;
      chk(!txe && chside, "R12 state after ignored write", {txe, chside}, 2'b01);
      run_frame(2'd1, 2'd0, 1'b0, 1'b0, 32'h0000_A1A1, 32'h0000_0F0F, 1'b0, 1'b1, 100);

      // R9 R10: left sample arriving during left slot waits a frame; master repeats
      do_reset();
      cfg_std = 2'd1;
      @(negedge clk); en = 1'b1;
      fork
         capture(64, 40, sdv, wsv, mb, per);
         begin repeat (8) @(negedge clk); write_word(16'h1234); end
      join
      esd = '0; ews = '0;
      for (int p = 0; p < 64; p++) begin
         esd[p] = (p < 32) ? 1'b0 : exp_sd(2'd1, 2'd0, 1'b0, 32'h1234, 32'h1234, p);
         ews[p] = exp_ws(2'd1, 2'd0, 1'b0, 1'b0, p);
      end
      chk(sdv[31:0] == esd[31:0], "R9 right slot skips left sample", sdv[31:0], esd[31:0]);
      chk(sdv[63:32] == esd[63:32], "R10 repeat of last sample", sdv[63:32], esd[63:32]);
      chk(wsv == ews, "R5 word select over two frames", wsv, ews);
      chk(!udr, "R10 no underflow in master", udr, 0);
      repeat (6) @(negedge clk);
      chk(!busy, "R13 stop after second frame", busy, 0);

      // R11: follower mode underflow
      do_reset();
      cfg_slave = 1'b1;
      slv_run = 1'b1;
      fork
         while (slv_run) begin #(4 * CLK_P) sck_in = ~sck_in; end
         begin
            @(negedge clk); en = 1'b1; @(negedge clk); en = 1'b0;
            @(negedge clk);
            chk(udr, "R11 underflow on empty slot", udr, 1);
            write_word(16'h0F0F);
            chk(!udr, "R11 underflow cleared by write", udr, 0);
            chk(!sck_out, "R11 bit clock output quiet", sck_out, 0);
            wait (!busy);
            chk(!busy, "R11 follower frame completes", busy, 0);
            slv_run = 1'b0;
         end
      join

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule